// File: doc/BRIEF.md
# Protection Configuration Write Guard with Rising Security Level

This block keeps the global protection-control state of a memory protection unit and filters every software write to the per-entry configuration bytes and address registers. The global state has two parts. The first is a two-bit security level that can only go up between resets. The second is a default-closed flag that can only be set. Each configuration byte holds a two-bit privilege/lock field, a match-mode field and the execute, write and read permission bits.

For each write, the block decides whether the byte is stored as written, stored in a legalized form, or dropped. The decision depends on the current security level and on the lock state of the entries involved. It also reports, for each entry, whether that entry is currently locked. Stored bytes and address registers can be read back, so software can see what was kept. Address matching and the access-permission decision are left to other logic.

All legality checks use the registered level and lock state. A level write and a configuration write made in the same cycle are therefore judged against the level that was in force before that cycle.

Top module: `pmp_cfg_guard`

## Requirements
- R1: The security level resets to 0. A level write stores its value only when that value is higher than the stored level. Otherwise the level is unchanged.
- R2: The default-closed flag resets to 0. Writing 1 sets it. Writing 0 never clears it before the next reset.
- R3: The configuration byte layout is bits 7:6 privilege/lock field, bit 5 reserved (always stored as 0), bits 4:3 match mode (1 = top-of-range), bit 2 execute, bit 1 write, bit 0 read.
- R4: At security level 0, a written privilege/lock value of 1 is stored as 0 and a value of 3 is stored as 2. The other fields are stored as written.
- R5: At security levels 1 to 3, all four privilege/lock values are stored as written.
- R6: An entry reports locked when its stored privilege/lock field is 2, or when it is 3 and the level is 3. Fields 0 and 1 never lock.
- R7: A configuration write to a locked entry leaves its byte unchanged.
- R8: At security level 3, a configuration write with bit 7 set and bit 2 set is dropped entirely.
- R9: An address write is dropped when its entry is locked, or when the next entry is locked and uses top-of-range matching. Otherwise the written value is stored.
- R10: Raising the level to 3 locks every entry already holding field value 3 from the next cycle on, without changing the stored byte.
- R11: A configuration write is judged against the level stored before any level write made in the same cycle.
- R12: Read-back returns the stored, legalized configuration byte and the stored address value. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_we | input | 1 | Security level write strobe |
| lvl_wdata | input | 2 | Requested security level |
| dflt_we | input | 1 | Default-closed write strobe |
| dflt_wdata | input | 1 | Requested default-closed value |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | IDX_W | Entry selected for the configuration write |
| cfg_wdata | input | 8 | Configuration byte to write |
| addr_we | input | 1 | Address register write strobe |
| addr_idx | input | IDX_W | Entry selected for the address write |
| addr_wdata | input | ADDR_W | Address value to write |
| rd_idx | input | IDX_W | Entry selected for read-back |
| cfg_rdata | output | 8 | Stored configuration byte of the selected entry |
| addr_rdata | output | ADDR_W | Stored address of the selected entry |
| sec_level | output | 2 | Current security level |
| dflt_closed | output | 1 | Current default-closed flag |
| entry_locked | output | N_ENTRIES | Per-entry lock indication |

## Verification
Configuration writes are applied with every privilege/lock value at level 0 and again at levels 1 and 3. This separates the folding of odd field values from plain storage. At level 3, writes that differ only in the execute bit or in bit 7 show that exactly the locked-and-executable combination is refused. Address writes aimed at an entry below a locked top-of-range entry, at a locked entry, and below a locked entry that does not use top-of-range distinguish the neighbour rule from ordinary lock gating. Level writes that go down, and a level write combined with a configuration write in the same cycle, show monotonic level behaviour and the use of the old level in the legality check.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

    typedef logic [1:0] sec_level_t;
    typedef logic [7:0] cfg_byte_t;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

    localparam int PRIV_HI = 7;
    localparam int PRIV_LO = 6;
    localparam int RSVD_B  = 5;
    localparam int MODE_HI = 4;
    localparam int MODE_LO = 3;
    localparam int EXEC_B  = 2;

    localparam sec_level_t LEVEL_TOP = 2'd3;

    function automatic logic [1:0] priv_field(input cfg_byte_t b);
        return b[PRIV_HI:PRIV_LO];
    endfunction

    function automatic match_mode_e mode_field(input cfg_byte_t b);
        return match_mode_e'(b[MODE_HI:MODE_LO]);
    endfunction

    // Field 2 always locks; field 3 locks only at the top level.
    function automatic logic entry_is_locked(input cfg_byte_t b, input sec_level_t lvl);
        logic [1:0] pl;
        pl = priv_field(b);
        return (pl == 2'd2) || ((pl == 2'd3) && (lvl == LEVEL_TOP));
    endfunction

endpackage

// File: rtl/pmp_level_ctrl.sv
module pmp_level_ctrl
    import pmp_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_we,
    input  sec_level_t lvl_wdata,
    input  logic       dflt_we,
    input  logic       dflt_wdata,
    output sec_level_t lvl_o,
    output logic       dflt_o
);

    typedef struct packed {
        sec_level_t lvl;
        logic       dflt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (lvl_we && (lvl_wdata > ctl_q.lvl)) begin
            ctl_d.lvl = lvl_wdata;
        end
        if (dflt_we && dflt_wdata) begin
            ctl_d.dflt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign lvl_o  = ctl_q.lvl;
    assign dflt_o = ctl_q.dflt;

    AST_LEVEL_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o >= $past(lvl_o)); // R1
    AST_LEVEL_FOLLOWS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_we && (lvl_wdata > lvl_o)) |=> (lvl_o == $past(lvl_wdata))); // R1
    AST_DFLT_STAYS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_o |=> dflt_o); // R2

endmodule

// File: rtl/pmp_lock_map.sv
module pmp_lock_map
    import pmp_guard_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  cfg_byte_t [N_ENTRIES-1:0] cfg_i,
    input  sec_level_t                lvl_i,
    output logic [N_ENTRIES-1:0]      locked_o,
    output logic [N_ENTRIES-1:0]      addr_block_o
);

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        assign locked_o[i] = entry_is_locked(cfg_i[i], lvl_i);
        if (i < N_ENTRIES - 1) begin : g_with_upper
            // A locked top-of-range entry also freezes the base below it.
            assign addr_block_o[i] = locked_o[i] ||
                (locked_o[i+1] && (mode_field(cfg_i[i+1]) == MATCH_TOR));
        end else begin : g_last
            assign addr_block_o[i] = locked_o[i];
        end
    end

endmodule

// File: rtl/pmp_cfg_filter.sv
module pmp_cfg_filter
    import pmp_guard_pkg::*;
(
    input  sec_level_t lvl_i,
    input  logic       target_locked_i,
    input  cfg_byte_t  wdata_i,
    output logic       apply_o,
    output cfg_byte_t  legal_o
);

    logic locked_exec;

    always_comb begin
        locked_exec = (lvl_i == LEVEL_TOP) && wdata_i[PRIV_HI] && wdata_i[EXEC_B];
        apply_o     = !target_locked_i && !locked_exec;

        legal_o          = wdata_i;
        legal_o[RSVD_B]  = 1'b0;
        if (lvl_i == 2'd0) begin
            legal_o[PRIV_LO] = 1'b0;
        end
    end

endmodule

// File: rtl/pmp_cfg_guard.sv
module pmp_cfg_guard
    import pmp_guard_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lvl_we,
    input  logic [1:0]           lvl_wdata,
    input  logic                 dflt_we,
    input  logic                 dflt_wdata,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [7:0]           cfg_wdata,
    input  logic                 addr_we,
    input  logic [IDX_W-1:0]     addr_idx,
    input  logic [ADDR_W-1:0]    addr_wdata,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           cfg_rdata,
    output logic [ADDR_W-1:0]    addr_rdata,
    output logic [1:0]           sec_level,
    output logic                 dflt_closed,
    output logic [N_ENTRIES-1:0] entry_locked
);

    typedef struct packed {
        cfg_byte_t [N_ENTRIES-1:0]              cfg;
        logic [N_ENTRIES-1:0][ADDR_W-1:0]       addr;
    } table_t;

    table_t st_d, st_q;

    sec_level_t               lvl_cur;
    logic [N_ENTRIES-1:0]     addr_block;
    logic                     cfg_apply;
    cfg_byte_t                cfg_legal;

    pmp_level_ctrl u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_we     (lvl_we),
        .lvl_wdata  (lvl_wdata),
        .dflt_we    (dflt_we),
        .dflt_wdata (dflt_wdata),
        .lvl_o      (lvl_cur),
        .dflt_o     (dflt_closed)
    );

    pmp_lock_map #(.N_ENTRIES(N_ENTRIES)) u_locks (
        .cfg_i        (st_q.cfg),
        .lvl_i        (lvl_cur),
        .locked_o     (entry_locked),
        .addr_block_o (addr_block)
    );

    pmp_cfg_filter u_filter (
        .lvl_i           (lvl_cur),
        .target_locked_i (entry_locked[cfg_idx]),
        .wdata_i         (cfg_wdata),
        .apply_o         (cfg_apply),
        .legal_o         (cfg_legal)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we && cfg_apply) begin
            st_d.cfg[cfg_idx] = cfg_legal;
        end
        if (addr_we && !addr_block[addr_idx]) begin
            st_d.addr[addr_idx] = addr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_level  = lvl_cur;
    assign cfg_rdata  = st_q.cfg[rd_idx];
    assign addr_rdata = st_q.addr[rd_idx];

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_chk
        AST_LOCKED_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            entry_locked[i] |=> $stable(st_q.cfg[i])); // R7
        AST_LOCKED_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            entry_locked[i] |=> $stable(st_q.addr[i])); // R9
        AST_LEVEL0_NO_ODD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_level == 2'd0) |-> !st_q.cfg[i][PRIV_LO]); // R4
        AST_TOP_LOCKS_FIELD3: assert property (@(posedge clk) disable iff (!rst_n)
            ((sec_level == LEVEL_TOP) && (st_q.cfg[i][PRIV_HI:PRIV_LO] == 2'd3))
            |-> entry_locked[i]); // R10
        AST_TOP_REFUSES_LOCKED_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && (cfg_idx == IDX_W'(i)) && (sec_level == LEVEL_TOP)
             && cfg_wdata[PRIV_HI] && cfg_wdata[EXEC_B])
            |=> $stable(st_q.cfg[i])); // R8
    end

endmodule

// File: tb/pmp_cfg_guard_test.sv
module pmp_cfg_guard_test;

    localparam int N  = 8;
    localparam int AW = 32;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvl_we = 1'b0, dflt_we = 1'b0, cfg_we = 1'b0, addr_we = 1'b0;
    logic [1:0] lvl_wdata = '0;
    logic dflt_wdata = 1'b0;
    logic [IW-1:0] cfg_idx = '0, addr_idx = '0, rd_idx = '0;
    logic [7:0] cfg_wdata = '0;
    logic [AW-1:0] addr_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [AW-1:0] addr_rdata;
    logic [1:0] sec_level;
    logic dflt_closed;
    logic [N-1:0] entry_locked;

    always #2 clk = ~clk;

    pmp_cfg_guard #(.N_ENTRIES(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
        .dflt_we(dflt_we), .dflt_wdata(dflt_wdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .addr_we(addr_we), .addr_idx(addr_idx), .addr_wdata(addr_wdata),
        .rd_idx(rd_idx), .cfg_rdata(cfg_rdata), .addr_rdata(addr_rdata),
        .sec_level(sec_level), .dflt_closed(dflt_closed), .entry_locked(entry_locked)
    );

    typedef enum int {K_CFG, K_ADDR, K_LVL, K_DFLT, K_LOCK} kind_e;
    typedef struct {
        string       tag;
        kind_e       kind;
        int          idx;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    logic mon_busy = 1'b0;
    logic done = 1'b0;

    task automatic expect_val(input string tag, input kind_e k, input int idx, input logic [31:0] e);
        item_t it;
        it.tag = tag; it.kind = k; it.idx = idx; it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // Monitor: pops expected items and compares against the read-back ports.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                mon_busy = 1'b1;
                it = sb_q.pop_front();
                rd_idx = IW'(it.idx);
                #1;
                case (it.kind)
                    K_CFG:  act = {24'd0, cfg_rdata};
                    K_ADDR: act = addr_rdata;
                    K_LVL:  act = {30'd0, sec_level};
                    K_DFLT: act = {31'd0, dflt_closed};
                    default: act = {24'd0, entry_locked};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
                mon_busy = 1'b0;
            end
        end
    end

    task automatic wr_cfg(input int i, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(i); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_addr(input int i, input logic [AW-1:0] d);
        @(negedge clk);
        addr_we = 1'b1; addr_idx = IW'(i); addr_wdata = d;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic wr_lvl(input logic [1:0] l);
        @(negedge clk);
        lvl_we = 1'b1; lvl_wdata = l;
        @(negedge clk);
        lvl_we = 1'b0;
    endtask

    task automatic wr_dflt(input logic v);
        @(negedge clk);
        dflt_we = 1'b1; dflt_wdata = v;
        @(negedge clk);
        dflt_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        expect_val("R1 reset level", K_LVL, 0, 0);
        expect_val("R2 reset flag", K_DFLT, 0, 0);
        expect_val("R6 reset locks", K_LOCK, 0, 0);
        expect_val("R12 reset cfg", K_CFG, 0, 0);
        expect_val("R12 reset addr", K_ADDR, 0, 0);
        drain();

        // Level 0 folding of odd privilege/lock values
        wr_cfg(0, 8'h47);
        wr_cfg(1, 8'hC9);
        wr_cfg(2, 8'h27);
        expect_val("R4 field1 folds to 0", K_CFG, 0, 32'h07);
        expect_val("R4 field3 folds to 2", K_CFG, 1, 32'h89);
        expect_val("R3 reserved bit cleared", K_CFG, 2, 32'h07);
        expect_val("R6 field2 locks", K_LOCK, 0, 32'h02);
        drain();

        // Address gating
        wr_addr(0, 32'h1234);
        wr_addr(1, 32'h5678);
        wr_addr(2, 32'h0055);
        expect_val("R9 below locked TOR dropped", K_ADDR, 0, 0);
        expect_val("R9 locked entry dropped", K_ADDR, 1, 0);
        expect_val("R9 free entry stored", K_ADDR, 2, 32'h55);
        drain();

        // Locked configuration byte
        wr_cfg(1, 8'h00);
        expect_val("R7 locked cfg unchanged", K_CFG, 1, 32'h89);
        drain();

        // Sticky default-closed flag
        wr_dflt(1'b1);
        expect_val("R2 flag set", K_DFLT, 0, 1);
        drain();
        wr_dflt(1'b0);
        expect_val("R2 flag stays set", K_DFLT, 0, 1);
        drain();

        // Same-cycle level raise and cfg write uses old level 0
        @(negedge clk);
        lvl_we = 1'b1; lvl_wdata = 2'd1;
        cfg_we = 1'b1; cfg_idx = 3'd3; cfg_wdata = 8'h41;
        @(negedge clk);
        lvl_we = 1'b0; cfg_we = 1'b0;
        expect_val("R11 judged at old level", K_CFG, 3, 32'h01);
        expect_val("R1 level raised to 1", K_LVL, 0, 1);
        drain();

        // Level 1 stores all field values
        wr_cfg(4, 8'hC4);
        wr_cfg(5, 8'h41);
        expect_val("R5 field3 kept", K_CFG, 4, 32'hC4);
        expect_val("R5 field1 kept", K_CFG, 5, 32'h41);
        expect_val("R6 field3 unlocked below top", K_LOCK, 0, 32'h02);
        drain();

        // Level cannot fall
        wr_lvl(2'd0);
        expect_val("R1 lower write ignored", K_LVL, 0, 1);
        drain();

        // Raise to top level
        wr_lvl(2'd3);
        expect_val("R1 level raised to 3", K_LVL, 0, 3);
        expect_val("R10 field3 now locked", K_LOCK, 0, 32'h12);
        expect_val("R10 byte not rewritten", K_CFG, 4, 32'hC4);
        drain();
        wr_cfg(4, 8'h00);
        expect_val("R7 newly locked cfg unchanged", K_CFG, 4, 32'hC4);
        drain();

        // Top level refuses locked executable entries
        wr_cfg(6, 8'h84);
        expect_val("R8 field2 with exec dropped", K_CFG, 6, 0);
        drain();
        wr_cfg(6, 8'hC5);
        expect_val("R8 field3 with exec dropped", K_CFG, 6, 0);
        drain();
        wr_cfg(6, 8'h44);
        wr_cfg(7, 8'h83);
        expect_val("R8 field1 with exec stored", K_CFG, 6, 32'h44);
        expect_val("R8 locked without exec stored", K_CFG, 7, 32'h83);
        expect_val("R6 final lock map", K_LOCK, 0, 32'h92);
        drain();

        // Locked entry above is not TOR: address below stays writable
        wr_addr(6, 32'hABCD);
        wr_addr(7, 32'h9999);
        expect_val("R9 below locked non-TOR stored", K_ADDR, 6, 32'hABCD);
        expect_val("R9 locked top entry dropped", K_ADDR, 7, 0);
        drain();

        done = 1'b1;
        finish_run();
    end

endmodule